// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block sequences instruction flow for a small accumulator-style processor core. Every input clock edge advances a phase counter through four non-overlapping strobes, and four phases form one instruction cycle. Fetch and execute overlap across two stages. While one instruction executes, the next one is read from program memory at the current fetch address. At the close of the last phase, that word is captured into the instruction register for the next cycle.

The sequencer owns the fetch address and decides how it moves. It normally advances by one, modulo the address width. When the execute logic reports a taken branch, the address loads the branch target instead. The word fetched alongside the branch is turned into a bubble, so every branch costs one empty cycle. The sequencer also produces the operand-read strobe and the destination-write strobe for data memory. Both are gated by a valid flag on the execute stage. A cycle-start pulse and a one-hot phase bus are exported so the surrounding logic can align to the phases.

Top module: `qphase_seq`

## Requirements
- R1: While reset is held, the phase bus reads 4'b0001 (first phase only), the fetch address equals RESET_VEC, and the execute-valid flag is 0. The first instruction cycle after reset therefore executes as a bubble.
- R2: Exactly one bit of the phase bus is high in every clock. The phases rotate bit0 → bit1 → bit2 → bit3 → bit0, one step per clock. The cycle-start output is high exactly when bit0 is high.
- R3: The fetch address changes only on the clock edge that ends the fourth phase. It then becomes visible in the first phase of the new cycle. With no taken branch, it advances by one and wraps modulo 2^PC_W.
- R4: The fetch strobe is high exactly in the fourth phase. On the edge that ends that phase, the instruction register captures imem_data and the executing-address output captures the fetch address.
- R5: After a cycle that did not take a branch, the next execute cycle is valid. Straight-line code therefore completes one instruction per four clocks.
- R6: The data-read strobe equals (second phase AND execute valid). The data-write strobe equals (fourth phase AND execute valid AND wr_req).
- R7: When br_take is high in the fourth phase of a valid execute cycle, the next fetch address is br_target. The instruction captured at that edge is marked invalid. The branch therefore occupies two instruction cycles.
- R8: While execute valid is 0, br_take and wr_req have no effect. No write strobe is issued, and the fetch address still advances by one.
- R9: br_take and br_target are ignored during the first three phases. Only their values in the fourth phase influence the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one phase per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_data | input | INSN_W | Program-memory word at the fetch address |
| br_take | input | 1 | Execute logic requests a PC change |
| br_target | input | PC_W | Address to load on a taken branch |
| wr_req | input | 1 | Executing instruction writes a destination |
| phase | output | 4 | One-hot phase strobes, bit0 = first phase |
| cyc_start | output | 1 | Pulse in the first phase of each cycle |
| pc | output | PC_W | Current fetch address |
| fetch_stb | output | 1 | Program-memory fetch strobe |
| ir | output | INSN_W | Instruction register (execute stage) |
| ex_pc | output | PC_W | Address of the instruction in the register |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |

## Verification
The bench builds the sequencer with PC_W = 6, INSN_W = 12 and RESET_VEC = 6'h3C. With these values the fetch address wraps from 6'h3F to 6'h00 within the first few instruction cycles. Branches at small addresses are then followed through several loops within a few hundred clocks. The stub program puts a branch directly after another branch, so the branch bit lands in a flushed slot together with a write request. The bench also pulses a false branch with a junk target during the first three phases of every cycle.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam int NPHASE = 4;

  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2,
    PH_D = 2'd3
  } qphase_e;

  // Successor phase in the fixed rotation.
  function automatic qphase_e phase_next(input qphase_e p);
    case (p)
      PH_A:    phase_next = PH_B;
      PH_B:    phase_next = PH_C;
      PH_C:    phase_next = PH_D;
      default: phase_next = PH_A;
    endcase
  endfunction

endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [NPHASE-1:0] strobes,
  output logic              cyc_first,
  output logic              cyc_last
);

  qphase_e ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_A;
    else        ph_q <= phase_next(ph_q);
  end

  for (genvar i = 0; i < NPHASE; i++) begin : g_strobe
    assign strobes[i] = (ph_q == qphase_e'(2'(i)));
  end

  assign cyc_first = strobes[0];
  assign cyc_last  = strobes[NPHASE-1];

endmodule

// File: rtl/qseq_pc_unit.sv
module qseq_pc_unit #(
  parameter int              PC_W      = 9,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);

  // Sequential successor, wrapping at the top of the address space.
  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] a);
    pc_step = a + PC_W'(1);
  endfunction

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= RESET_VEC;
    else if (advance) pc_q <= redirect ? target : pc_step(pc_q);
  end

  assign pc = pc_q;

endmodule

// File: rtl/qseq_pipe_reg.sv
module qseq_pipe_reg #(
  parameter int INSN_W = 12,
  parameter int PC_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic              kill,
  input  logic [INSN_W-1:0] fetch_word,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic [INSN_W-1:0] ir,
  output logic [PC_W-1:0]   ex_pc,
  output logic              ex_valid
);

  logic [INSN_W-1:0] ir_q;
  logic [PC_W-1:0]   expc_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q   <= '0;
      expc_q <= '0;
      vld_q  <= 1'b0;
    end else if (latch) begin
      ir_q   <= fetch_word;
      expc_q <= fetch_pc;
      vld_q  <= !kill;
    end
  end

  assign ir       = ir_q;
  assign ex_pc    = expc_q;
  assign ex_valid = vld_q;

endmodule

// File: rtl/qphase_seq.sv
module qphase_seq
  import qseq_pkg::*;
#(
  parameter int              PC_W      = 9,
  parameter int              INSN_W    = 12,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] imem_data,
  input  logic              br_take,
  input  logic [PC_W-1:0]   br_target,
  input  logic              wr_req,
  output logic [3:0]        phase,
  output logic              cyc_start,
  output logic [PC_W-1:0]   pc,
  output logic              fetch_stb,
  output logic [INSN_W-1:0] ir,
  output logic [PC_W-1:0]   ex_pc,
  output logic              ex_valid,
  output logic              dm_rd,
  output logic              dm_wr
);

  logic [NPHASE-1:0] strb;
  logic              first_ph;
  logic              last_ph;
  logic              redirect;   // taken branch accepted this cycle
  logic              vld;
  logic [PC_W-1:0]   pc_w;

  qseq_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strb),
    .cyc_first (first_ph),
    .cyc_last  (last_ph)
  );

  assign redirect = last_ph && vld && br_take;

  qseq_pc_unit #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (last_ph),
    .redirect (redirect),
    .target   (br_target),
    .pc       (pc_w)
  );

  qseq_pipe_reg #(.INSN_W(INSN_W), .PC_W(PC_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch      (last_ph),
    .kill       (redirect),
    .fetch_word (imem_data),
    .fetch_pc   (pc_w),
    .ir         (ir),
    .ex_pc      (ex_pc),
    .ex_valid   (vld)
  );

  assign phase     = strb;
  assign cyc_start = first_ph;
  assign pc        = pc_w;
  assign fetch_stb = last_ph;
  assign ex_valid  = vld;
  assign dm_rd     = strb[1] && vld;
  assign dm_wr     = last_ph && vld && wr_req;

endmodule

// File: rtl/qseq_checker.sv
module qseq_checker #(
  parameter int PC_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      phase,
  input logic            cyc_start,
  input logic [PC_W-1:0] pc,
  input logic            fetch_stb,
  input logic            ex_valid,
  input logic            br_take,
  input logic [PC_W-1:0] br_target,
  input logic            wr_req,
  input logic            dm_rd,
  input logic            dm_wr
);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    phase[3] |=> phase[0]);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> phase[1]);
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start == phase[0]);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[3] |=> $stable(pc));
  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !(ex_valid && br_take)) |=> (pc == PC_W'($past(pc) + 1'b1)));
  a_r4_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> phase[3]);
  a_r5_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !(ex_valid && br_take)) |=> ex_valid);
  a_r6_rd: assert property (@(posedge clk) disable iff (!rst_n)
    dm_rd |-> (ex_valid && phase[1]));
  a_r6_wr: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wr |-> (ex_valid && phase[3] && wr_req));
  a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && ex_valid && br_take) |=> (pc == $past(br_target) && !ex_valid));
  a_r8_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |-> !dm_wr);

endmodule

bind qphase_seq qseq_checker #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .cyc_start (cyc_start),
  .pc        (pc),
  .fetch_stb (fetch_stb),
  .ex_valid  (ex_valid),
  .br_take   (br_take),
  .br_target (br_target),
  .wr_req    (wr_req),
  .dm_rd     (dm_rd),
  .dm_wr     (dm_wr)
);

// File: tb/sim_qphase_seq.sv
module sim_qphase_seq;

  localparam int         PW = 6;
  localparam int         IW = 12;
  localparam logic [5:0] RV = 6'h3C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] imem_data;
  logic          br_take;
  logic [PW-1:0] br_target;
  logic          wr_req;
  logic [3:0]    phase;
  logic          cyc_start;
  logic [PW-1:0] pc;
  logic          fetch_stb;
  logic [IW-1:0] ir;
  logic [PW-1:0] ex_pc;
  logic          ex_valid;
  logic          dm_rd;
  logic          dm_wr;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  bit  glitch_en = 1'b0;

  always #5 clk = ~clk;

  qphase_seq #(.PC_W(PW), .INSN_W(IW), .RESET_VEC(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_data(imem_data), .br_take(br_take),
    .br_target(br_target), .wr_req(wr_req), .phase(phase),
    .cyc_start(cyc_start), .pc(pc), .fetch_stb(fetch_stb), .ir(ir),
    .ex_pc(ex_pc), .ex_valid(ex_valid), .dm_rd(dm_rd), .dm_wr(dm_wr)
  );

  // Stub program: bit11 = branch, bit10 = write, bits5:0 = target.
  function automatic logic [IW-1:0] rom(input logic [5:0] a);
    case (a)
      6'h05:   rom = {1'b1, 1'b1, 4'h0, 6'h20};
      6'h06:   rom = {1'b1, 1'b1, 4'h0, 6'h10};
      6'h22:   rom = {1'b1, 1'b0, 4'h0, 6'h3E};
      default: rom = {1'b0, a[0], 4'h0, a ^ 6'h15};
    endcase
  endfunction

  // Stub execute logic; a false branch is pulsed outside the fourth phase (R9).
  logic glitch;
  assign glitch    = glitch_en && !phase[3];
  assign imem_data = rom(pc);
  assign br_take   = ir[11] | glitch;
  assign br_target = glitch ? 6'h11 : ir[5:0];
  assign wr_req    = ir[10];

  typedef struct packed {
    bit       v;
    bit [5:0] ex;
    bit [5:0] fa;
  } item_t;

  item_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: expected per-cycle fetch address and execute slot.
  task automatic plan(input int n);
    bit [5:0] fa = RV;
    bit [5:0] ex = '0;
    bit       v  = 1'b0;
    for (int i = 0; i < n; i++) begin
      item_t it;
      bit [5:0] nfa;
      bit       nv;
      it.v = v; it.ex = ex; it.fa = fa;
      exp_q.push_back(it);
      if (v && rom(ex)[11]) begin nfa = rom(ex)[5:0]; nv = 1'b0; end
      else                  begin nfa = fa + 6'd1;   nv = 1'b1; end
      ex = fa; fa = nfa; v = nv;
    end
  endtask

  // Monitor: pops one item per instruction cycle and compares at negedges.
  initial begin
    item_t cur;
    cur = '0;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        check($countones(phase) == 1, "R2 onehot", phase, 0);
        check(cyc_start == phase[0], "R2 cyc_start", cyc_start, phase[0]);
        check(fetch_stb == phase[3], "R4 fetch_stb", fetch_stb, phase[3]);
        if (phase[0]) begin
          if (exp_q.size() == 0) done = 1'b1;
          else cur = exp_q.pop_front();
        end
        if (!done) begin
          check(pc == cur.fa, "R3 pc", pc, cur.fa);
          check(ex_valid == cur.v, "R5/R7 ex_valid", ex_valid, cur.v);
          if (cur.v) begin
            check(ex_pc == cur.ex, "R4 ex_pc", ex_pc, cur.ex);
            check(ir == rom(cur.ex), "R4 ir", ir, rom(cur.ex));
          end
          check(dm_rd == (phase[1] && cur.v), "R6 dm_rd", dm_rd, phase[1] && cur.v);
          check(dm_wr == (phase[3] && cur.v && rom(cur.ex)[10]), "R6/R8 dm_wr",
                dm_wr, phase[3] && cur.v && rom(cur.ex)[10]);
        end
      end
    end
  end

  initial begin
    plan(48);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(phase == 4'b0001, "R1 phase", phase, 1);
    check(pc == RV, "R1 pc", pc, RV);
    check(ex_valid == 1'b0, "R1 ex_valid", ex_valid, 0);
    check(dm_wr == 1'b0, "R1 dm_wr", dm_wr, 0);
    glitch_en = 1'b1;
    @(posedge clk);
    #2 rst_n = 1'b1;
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule